// File: doc/BRIEF.md
# I2C Target Address Recognizer with Two Own Addresses

This block decides whether an I2C target should answer the address phase of a transfer. A bit-level receiver in front of it delivers each address byte as a parallel value, together with a strobe. One strobe marks the first byte after a START or repeated START. The other marks the byte that follows it. The block compares the byte against its enabled addresses and answers one cycle later.

There are two own addresses:
- The first is either a 7-bit address or a 10-bit address.
- The second is always a 7-bit address. A 3-bit mask code can widen it so that it covers a block of addresses.

Reception of the general call address can be switched on as well.

The response has two parts:
- A one-cycle acknowledge or not-acknowledge pulse, which goes to the stage that drives the ACK bit.
- A sticky matched flag with the direction bit and a 7-bit match code. For a 7-bit address, the code is the received address. For a 10-bit address, the code is the header pattern `11110xx`, which is how it can be told apart from a 7-bit address.

Software sets the configuration while the block is disabled. While the block is enabled, the configuration is held frozen. Software clears the flag with a strobe once the transfer has been handled.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `matched`, `dir`, `code`, `ack` and `nack` are all zero.
- R2: In 7-bit mode, own address 1 compares `rx_byte[7:1]` with `oa1_addr[7:1]`. On a hit, `ack` pulses in the cycle after the strobe, `matched` rises, `dir` takes `rx_byte[0]` (0 write, 1 read) and `code` takes `rx_byte[7:1]`.
- R3: Own address 2 compares `rx_byte[7:1]` with `oa2_addr`, ignoring the N lowest bits when `oa2_mask` = N. A value of 0 requires an exact compare.
- R4: In 10-bit mode, a first byte whose upper five bits are `11110` is a header.
  - It is claimed when bits 2:1 equal `oa1_addr[9:8]`.
  - A claimed header with bit 0 = 0 gets `ack` but leaves `matched` unchanged.
  - The next byte then gets `ack` and sets `matched` with `dir` = 0 and `code` = header bits 7:1 when it equals `oa1_addr[7:0]`. Otherwise it gets `nack`.
- R5: A claimed 10-bit header with bit 0 = 1 matches only if a full 10-bit address has matched since the last clear. It then sets `dir` = 1 and `code` = header bits 7:1. Otherwise it gets `nack`.
- R6: The byte 0x00 matches, with `code` = 0 and `dir` = 0, only when `gcall_on` is 1.
- R7: With both own addresses enabled, a byte that hits either one sets `matched`.
- R8: Configuration inputs are taken in only while `enable` is 0. Changes made while `enable` is 1 have no effect on matching.
- R9: `matched` stays high until `clr`. A new match while it is high updates `dir` and `code`. A match in the same cycle as `clr` wins over the clear.
- R10: A first byte that matches nothing gives a `nack` pulse and leaves `matched`, `dir` and `code` unchanged.
- R11: While `enable` is 0, strobes produce neither `ack` nor `nack` and never set `matched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Matching enable; configuration loads while low |
| clr | input | 1 | Clears the matched flag and the 10-bit history |
| oa1_on | input | 1 | Own address 1 enable |
| oa1_ten | input | 1 | Own address 1 is 10-bit when 1 |
| oa1_addr | input | 10 | Own address 1 (7-bit value in bits 7:1) |
| oa2_on | input | 1 | Own address 2 enable |
| oa2_addr | input | 7 | Own address 2 |
| oa2_mask | input | 3 | Number of low bits of address 2 ignored |
| gcall_on | input | 1 | General call reception enable |
| first_vld | input | 1 | Strobe: first byte after START |
| next_vld | input | 1 | Strobe: byte following the first |
| rx_byte | input | 8 | Received byte |
| matched | output | 1 | Sticky address-matched flag |
| dir | output | 1 | Latched direction bit |
| code | output | 7 | Latched match code |
| ack | output | 1 | One-cycle acknowledge pulse |
| nack | output | 1 | One-cycle not-acknowledge pulse |

## Verification
The assertions check several properties on every cycle:
- `ack` and `nack` are mutually exclusive.
- The flag only rises together with an acknowledge.
- The flag persists until a clear.
- A clear takes effect unless it is overridden by a simultaneous match.
- The block stays silent while disabled.
- `dir` and `code` hold steady across a rejected byte.

Only the directed scenarios can show that the compared values are right. These scenarios cover:
- the width of each mask code;
- the two-byte 10-bit sequence and the rule for the read header;
- the general call gate;
- the freezing of the configuration while the block is enabled.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       clr,
  input  logic       oa1_on,
  input  logic       oa1_ten,
  input  logic [9:0] oa1_addr,
  input  logic       oa2_on,
  input  logic [6:0] oa2_addr,
  input  logic [2:0] oa2_mask,
  input  logic       gcall_on,
  input  logic       first_vld,
  input  logic       next_vld,
  input  logic [7:0] rx_byte,
  output logic       matched,
  output logic       dir,
  output logic [6:0] code,
  output logic       ack,
  output logic       nack
);

  logic       s_oa1_on, s_oa1_ten, s_oa2_on, s_gc;
  logic [9:0] s_oa1;
  logic [6:0] s_oa2;
  logic [2:0] s_msk;
  logic       pend, ten_ok;
  logic [6:0] hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_oa1_on  <= 1'b0;
      s_oa1_ten <= 1'b0;
      s_oa1     <= '0;
      s_oa2_on  <= 1'b0;
      s_oa2     <= '0;
      s_msk     <= '0;
      s_gc      <= 1'b0;
    end else if (!enable) begin
      s_oa1_on  <= oa1_on;
      s_oa1_ten <= oa1_ten;
      s_oa1     <= oa1_addr;
      s_oa2_on  <= oa2_on;
      s_oa2     <= oa2_addr;
      s_msk     <= oa2_mask;
      s_gc      <= gcall_on;
    end
  end

  wire [6:0] keep   = 7'h7F << s_msk;
  wire       is_hdr = s_oa1_on && s_oa1_ten && rx_byte[7:3] == 5'b11110
                      && rx_byte[2:1] == s_oa1[9:8];
  wire       hit1   = s_oa1_on && !s_oa1_ten && rx_byte[7:1] == s_oa1[7:1];
  wire       hit2   = s_oa2_on && ((rx_byte[7:1] ^ s_oa2) & keep) == 7'd0;
  wire       hitgc  = s_gc && rx_byte == 8'h00;
  wire       hit7   = hit1 || hit2 || hitgc;
  wire       low_ok = rx_byte == s_oa1[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched <= 1'b0;
      dir     <= 1'b0;
      code    <= '0;
      ack     <= 1'b0;
      nack    <= 1'b0;
      pend    <= 1'b0;
      ten_ok  <= 1'b0;
      hdr_q   <= '0;
    end else begin
      ack  <= 1'b0;
      nack <= 1'b0;
      if (clr) begin
        matched <= 1'b0;
        ten_ok  <= 1'b0;
      end
      if (!enable) begin
        pend <= 1'b0;
      end else if (first_vld) begin
        pend <= 1'b0;
        if (is_hdr) begin
          if (!rx_byte[0]) begin
            pend  <= 1'b1;
            hdr_q <= rx_byte[7:1];
            ack   <= 1'b1;
          end else if (ten_ok && !clr) begin
            matched <= 1'b1;
            dir     <= 1'b1;
            code    <= rx_byte[7:1];
            ack     <= 1'b1;
          end else begin
            nack <= 1'b1;
          end
        end else if (hit7) begin
          matched <= 1'b1;
          dir     <= rx_byte[0];
          code    <= rx_byte[7:1];
          ack     <= 1'b1;
        end else begin
          nack <= 1'b1;
        end
      end else if (next_vld && pend) begin
        pend <= 1'b0;
        if (low_ok) begin
          matched <= 1'b1;
          ten_ok  <= 1'b1;
          dir     <= 1'b0;
          code    <= hdr_q;
          ack     <= 1'b1;
        end else begin
          nack <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       clr,
  input logic       matched,
  input logic       dir,
  input logic [6:0] code,
  input logic       ack,
  input logic       nack
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(ack && nack));

  p_rise_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched) |-> ack);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    matched && !clr |=> matched);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!matched || ack));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ack && !nack));

  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> ($stable(dir) && $stable(code)));

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clr(clr),
  .matched(matched), .dir(dir), .code(code), .ack(ack), .nack(nack)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, clr = 1'b0;
  logic       oa1_on = 1'b0, oa1_ten = 1'b0, oa2_on = 1'b0, gcall_on = 1'b0;
  logic [9:0] oa1_addr = '0;
  logic [6:0] oa2_addr = '0;
  logic [2:0] oa2_mask = '0;
  logic       first_vld = 1'b0, next_vld = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       matched, dir, ack, nack;
  logic [6:0] code;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  i2c_addr_match uut (.*);

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic config_set(input logic a1on, input logic a1ten, input logic [9:0] a1,
                            input logic a2on, input logic [6:0] a2, input logic [2:0] m,
                            input logic gc);
    @(negedge clk);
    enable = 1'b0;
    oa1_on = a1on; oa1_ten = a1ten; oa1_addr = a1;
    oa2_on = a2on; oa2_addr = a2; oa2_mask = m; gcall_on = gc;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic send(input logic second, input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
    first_vld = !second;
    next_vld = second;
    @(negedge clk);
    first_vld = 1'b0;
    next_vld = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 matched", matched, 0);
    chk("R1 dir", dir, 0);
    chk("R1 code", code, 0);
    chk("R1 ack", ack, 0);
    chk("R1 nack", nack, 0);
  endtask

  task automatic t_oa1_7bit();
    config_set(1, 0, {2'b00, 7'h3A, 1'b0}, 0, 7'h00, 0, 0);
    send(0, 8'h75);
    chk("R2 ack", ack, 1);
    chk("R2 matched", matched, 1);
    chk("R2 dir", dir, 1);
    chk("R2 code", code, 7'h3A);
    send(0, 8'h74);
    chk("R9 repeated start dir", dir, 0);
    chk("R9 still matched", matched, 1);
    send(0, 8'h20);
    chk("R10 nack", nack, 1);
    chk("R10 ack", ack, 0);
    chk("R10 dir kept", dir, 0);
    chk("R10 code kept", code, 7'h3A);
    chk("R10 flag kept", matched, 1);
    do_clr();
    chk("R9 cleared", matched, 0);
  endtask

  task automatic t_oa2_mask();
    config_set(0, 0, 10'h0, 1, 7'h50, 3'd2, 0);
    send(0, 8'hA6);
    chk("R3 mask2 hit", ack, 1);
    chk("R3 mask2 code", code, 7'h53);
    send(0, 8'hA8);
    chk("R3 mask2 miss", nack, 1);
    do_clr();
    config_set(0, 0, 10'h0, 1, 7'h50, 3'd0, 0);
    send(0, 8'hA2);
    chk("R3 mask0 miss", nack, 1);
    chk("R3 mask0 no flag", matched, 0);
    send(0, 8'hA0);
    chk("R3 mask0 hit", ack, 1);
    do_clr();
    config_set(0, 0, 10'h0, 1, 7'h50, 3'd7, 0);
    send(0, 8'h0B);
    chk("R3 mask7 any", ack, 1);
    do_clr();
  endtask

  task automatic t_ten_bit();
    config_set(1, 1, 10'h2C5, 0, 7'h00, 0, 0);
    send(0, 8'hF5);
    chk("R5 read header before match nack", nack, 1);
    send(0, 8'hF4);
    chk("R4 header ack", ack, 1);
    chk("R4 header no flag", matched, 0);
    send(1, 8'hC5);
    chk("R4 second ack", ack, 1);
    chk("R4 flag", matched, 1);
    chk("R4 dir", dir, 0);
    chk("R4 code", code, 7'h7A);
    send(0, 8'hF5);
    chk("R5 read header ack", ack, 1);
    chk("R5 dir", dir, 1);
    chk("R5 code", code, 7'h7A);
    do_clr();
    send(0, 8'hF4);
    send(1, 8'hC4);
    chk("R4 wrong low byte nack", nack, 1);
    chk("R4 wrong low byte no flag", matched, 0);
    send(0, 8'hF2);
    chk("R4 wrong header bits nack", nack, 1);
    send(0, 8'hF5);
    chk("R5 history cleared", nack, 1);
  endtask

  task automatic t_gcall();
    config_set(0, 0, 10'h0, 0, 7'h00, 0, 0);
    send(0, 8'h00);
    chk("R6 gc off nack", nack, 1);
    config_set(0, 0, 10'h0, 0, 7'h00, 0, 1);
    send(0, 8'h00);
    chk("R6 gc on ack", ack, 1);
    chk("R6 gc code", code, 0);
    chk("R6 gc dir", dir, 0);
    do_clr();
  endtask

  task automatic t_both();
    config_set(1, 0, {2'b00, 7'h12, 1'b0}, 1, 7'h34, 0, 0);
    send(0, 8'h24);
    chk("R7 via oa1", matched, 1);
    do_clr();
    send(0, 8'h69);
    chk("R7 via oa2", matched, 1);
    chk("R7 code", code, 7'h34);
    do_clr();
  endtask

  task automatic t_freeze();
    config_set(1, 0, {2'b00, 7'h22, 1'b0}, 0, 7'h00, 0, 0);
    @(negedge clk);
    oa1_addr = {2'b00, 7'h33, 1'b0};
    send(0, 8'h44);
    chk("R8 old address kept", ack, 1);
    do_clr();
    send(0, 8'h66);
    chk("R8 new address ignored", nack, 1);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    enable = 1'b0;
    send(0, 8'h66);
    chk("R11 no ack", ack, 0);
    chk("R11 no nack", nack, 0);
    chk("R11 no flag", matched, 0);
  endtask

  task automatic t_clr_race();
    config_set(1, 0, {2'b00, 7'h22, 1'b0}, 0, 7'h00, 0, 0);
    @(negedge clk);
    rx_byte = 8'h44; first_vld = 1'b1; clr = 1'b1;
    @(negedge clk);
    first_vld = 1'b0; clr = 1'b0;
    chk("R9 match beats clear", matched, 1);
    do_clr();
    chk("R9 clear alone", matched, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_oa1_7bit();
    t_oa2_mask();
    t_ten_bit();
    t_gcall();
    t_both();
    t_freeze();
    t_disabled();
    t_clr_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule